// File: doc/BRIEF.md
# Multiplexer-Based Eight-Bit ALU

This block is an eight-bit arithmetic-logic unit. It has no logic unit of its own. For every operation, each bit position has two small 4:1 multiplexers, and each one works as a programmable two-input function generator. The operation select loads a four-entry truth table into each multiplexer. Both tables are indexed by the pair formed from the accumulator bit and the bus bit. The two generated bits, with a carry, enter a ripple-carry adder built from two four-bit slices. Addition, subtraction, the three bitwise functions and the operand pass-throughs all travel this one path.

The accumulator operand `a_i` and the bus operand `b_i` are presented together with a three-bit operation code. The result and the carry-out leave through an output register, which a parameter can remove to leave a purely combinational path. The block has no control states. Its only sequential element is the optional output register. That register has two conditions: held clear while reset is asserted, and loading the new result on every clock edge after reset.

Top module: `mux_alu_top`

## Requirements
- R1: With op code 4 (add), the result is (A + B) mod 256 and the carry-out is bit 8 of the unsigned sum.
- R2: With op code 5 (subtract), the result is (A − B) mod 256 and the carry-out is 1 exactly when A ≥ B (no borrow).
- R3: With op code 1, the result is the bitwise AND of A and B.
- R4: With op code 2, the result is the bitwise OR of A and B.
- R5: With op code 3, the result is the bitwise XOR of A and B.
- R6: With op codes 0 (load), 6 (store pass) and 7 (jump pass), the result equals B unchanged and A has no effect.
- R7: For op codes 0, 1, 2, 3, 6 and 7 the carry-out is 0.
- R8: With the output register present (default), the result and carry-out for inputs applied before a rising clock edge appear after that edge and hold until the next edge.
- R9: While the active-low reset is low, the result and carry-out are 0, whatever the inputs.
- R10: A carry out of bit 3 reaches bit 4, so that 0x0F + 0x01 gives 0x10 and 0x10 − 0x01 gives 0x0F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Bus operand |
| op_i | input | 3 | Operation code (0 load, 1 AND, 2 OR, 3 XOR, 4 add, 5 subtract, 6 store pass, 7 jump pass) |
| res_o | output | 8 | Result |
| cout_o | output | 1 | Carry-out, 0 for non-arithmetic codes |

## Verification
The bench checks the add and subtract edges where a truth table or carry-in is easily wrong. In 0xFF + 0x01 the carry must leave while the result wraps to zero. In 0x00 − 0x01 and in A = B, a wrong inverted table or a missing carry-in would give an off-by-one result or an inverted borrow. Sums that cross the slice boundary would come out short by 0x10 if the inter-slice carry were lost. Logic and pass codes are given operands that would produce a stray carry or would leak A into the result if the second table were not forced to zero. The bench also confirms that a new input does not change the output before the next edge.

// File: rtl/mux_alu_pkg.sv
package mux_alu_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_AND   = 3'd1,
        OP_OR    = 3'd2,
        OP_XOR   = 3'd3,
        OP_ADD   = 3'd4,
        OP_SUB   = 3'd5,
        OP_STPAS = 3'd6,
        OP_JMPAS = 3'd7
    } alu_op_e;

    // Truth tables indexed by {a_bit, b_bit}
    localparam logic [3:0] LUT_ZERO = 4'b0000;
    localparam logic [3:0] LUT_A    = 4'b1100;
    localparam logic [3:0] LUT_B    = 4'b1010;
    localparam logic [3:0] LUT_NB   = 4'b0101;
    localparam logic [3:0] LUT_AND  = 4'b1000;
    localparam logic [3:0] LUT_OR   = 4'b1110;
    localparam logic [3:0] LUT_XOR  = 4'b0110;

    typedef struct packed {
        logic [3:0] lut_l;
        logic [3:0] lut_r;
        logic       cin;
    } fn_cfg_t;

endpackage

// File: rtl/mux_alu_decode.sv
module mux_alu_decode
    import mux_alu_pkg::*;
(
    input  alu_op_e op_i,
    output fn_cfg_t cfg_o
);

    always_comb begin
        unique case (op_i)
            OP_ADD:   cfg_o = '{lut_l: LUT_A,   lut_r: LUT_B,    cin: 1'b0};
            OP_SUB:   cfg_o = '{lut_l: LUT_A,   lut_r: LUT_NB,   cin: 1'b1};
            OP_AND:   cfg_o = '{lut_l: LUT_AND, lut_r: LUT_ZERO, cin: 1'b0};
            OP_OR:    cfg_o = '{lut_l: LUT_OR,  lut_r: LUT_ZERO, cin: 1'b0};
            OP_XOR:   cfg_o = '{lut_l: LUT_XOR, lut_r: LUT_ZERO, cin: 1'b0};
            OP_LOAD,
            OP_STPAS,
            OP_JMPAS: cfg_o = '{lut_l: LUT_B,   lut_r: LUT_ZERO, cin: 1'b0};
            default:  cfg_o = '{lut_l: LUT_ZERO, lut_r: LUT_ZERO, cin: 1'b0};
        endcase
    end

endmodule

// File: rtl/mux_alu_fgen.sv
module mux_alu_fgen #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       lut_i,
    output logic [WIDTH-1:0] f_o
);

    // One 4:1 multiplexer per bit, selected by the operand bit pair
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign f_o[i] = lut_i[{a_i[i], b_i[i]}];
    end

endmodule

// File: rtl/mux_alu_slice.sv
module mux_alu_slice #(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] l_i,
    input  logic [SLICE_W-1:0] r_i,
    input  logic               cin_i,
    output logic [SLICE_W-1:0] sum_o,
    output logic               cout_o
);

    logic [SLICE_W:0] c;
    assign c[0] = cin_i;

    for (genvar i = 0; i < SLICE_W; i++) begin : g_fa
        assign sum_o[i] = l_i[i] ^ r_i[i] ^ c[i];
        assign c[i+1]   = (l_i[i] & r_i[i]) | (c[i] & (l_i[i] ^ r_i[i]));
    end

    assign cout_o = c[SLICE_W];

endmodule

// File: rtl/mux_alu_top.sv
module mux_alu_top
    import mux_alu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SLICE_W = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [2:0]        op_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);

    localparam int N_SLICE = DATA_W / SLICE_W;

    fn_cfg_t           cfg;
    logic [DATA_W-1:0] f_l;
    logic [DATA_W-1:0] f_r;
    logic [DATA_W-1:0] sum;
    logic [N_SLICE:0]  carry;

    mux_alu_decode u_dec (
        .op_i  (alu_op_e'(op_i)),
        .cfg_o (cfg)
    );

    mux_alu_fgen #(.WIDTH(DATA_W)) u_fgen_l (
        .a_i   (a_i),
        .b_i   (b_i),
        .lut_i (cfg.lut_l),
        .f_o   (f_l)
    );

    mux_alu_fgen #(.WIDTH(DATA_W)) u_fgen_r (
        .a_i   (a_i),
        .b_i   (b_i),
        .lut_i (cfg.lut_r),
        .f_o   (f_r)
    );

    assign carry[0] = cfg.cin;

    for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
        mux_alu_slice #(.SLICE_W(SLICE_W)) u_slice (
            .l_i    (f_l[s*SLICE_W +: SLICE_W]),
            .r_i    (f_r[s*SLICE_W +: SLICE_W]),
            .cin_i  (carry[s]),
            .sum_o  (sum[s*SLICE_W +: SLICE_W]),
            .cout_o (carry[s+1])
        );
    end

    if (REG_OUT) begin : g_reg_out
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                res_o  <= '0;
                cout_o <= 1'b0;
            end else begin
                res_o  <= sum;
                cout_o <= carry[N_SLICE];
            end
        end
    end else begin : g_comb_out
        assign res_o  = rst_ni ? sum : '0;
        assign cout_o = rst_ni & carry[N_SLICE];
    end

endmodule

// File: rtl/mux_alu_chk.sv
module mux_alu_chk
    import mux_alu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] res_o,
    input  logic              cout_o
);

    logic [DATA_W-1:0] q_a;
    logic [DATA_W-1:0] q_b;
    logic [2:0]        q_op;
    logic              primed;

    if (REG_OUT) begin : g_lag
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                q_a    <= '0;
                q_b    <= '0;
                q_op   <= '0;
                primed <= 1'b0;
            end else begin
                q_a    <= a_i;
                q_b    <= b_i;
                q_op   <= op_i;
                primed <= 1'b1;
            end
        end
    end else begin : g_nolag
        assign q_a    = a_i;
        assign q_b    = b_i;
        assign q_op   = op_i;
        assign primed = 1'b1;
    end

    p_add_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed && q_op == OP_ADD |-> {cout_o, res_o} == ({1'b0, q_a} + {1'b0, q_b}));

    p_sub_borrow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed && q_op == OP_SUB |-> res_o == DATA_W'(q_a - q_b) && cout_o == (q_a >= q_b));

    p_xor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed && q_op == OP_XOR |-> res_o == (q_a ^ q_b));

    p_pass_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed && (q_op == OP_LOAD || q_op == OP_STPAS || q_op == OP_JMPAS) |-> res_o == q_b);

    p_no_carry_logic_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        primed && q_op != OP_ADD && q_op != OP_SUB |-> !cout_o);

    p_reset_clear_r9: assert property (@(posedge clk_i)
        !rst_ni |=> !rst_ni || (res_o == '0 && !cout_o) || $past(rst_ni));

endmodule

bind mux_alu_top mux_alu_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (a_i),
    .b_i    (b_i),
    .op_i   (op_i),
    .res_o  (res_o),
    .cout_o (cout_o)
);

// File: tb/mux_alu_top_tb_top.sv
module mux_alu_top_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic [2:0] op_i = '0;
    logic [7:0] res_o;
    logic       cout_o;

    int n_chk = 0;
    int n_fail = 0;
    bit timed_out = 0;

    bit    pv = 0;
    int    p_res = 0;
    int    p_cout = 0;
    int    p_op = 0;
    string p_tag = "";

    always #5 clk_i = ~clk_i;

    mux_alu_top dut_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .a_i    (a_i),
        .b_i    (b_i),
        .op_i   (op_i),
        .res_o  (res_o),
        .cout_o (cout_o)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(int op);
        case (op)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R1";
            5: return "R2";
            default: return "R6";
        endcase
    endfunction

    // Compare the previous vector's result, then apply a new one
    task automatic step(int op, int a, int b, string tag);
        @(negedge clk_i);
        if (pv) begin
            chk(int'(res_o) == p_res, p_tag, int'(res_o), p_res);
            chk(int'(cout_o) == p_cout, (p_op == 4 || p_op == 5) ? p_tag : "R7",
                int'(cout_o), p_cout);
        end
        op_i = 3'(op);
        a_i  = 8'(a);
        b_i  = 8'(b);
        #1;
        if (pv) chk(int'(res_o) == p_res, "R8", int'(res_o), p_res);
        case (op)
            1: begin p_res = a & b; p_cout = 0; end
            2: begin p_res = a | b; p_cout = 0; end
            3: begin p_res = a ^ b; p_cout = 0; end
            4: begin p_res = (a + b) & 255; p_cout = (a + b) > 255 ? 1 : 0; end
            5: begin p_res = (a - b) & 255; p_cout = (a >= b) ? 1 : 0; end
            default: begin p_res = b; p_cout = 0; end
        endcase
        p_op  = op;
        p_tag = (tag == "") ? op_tag(op) : tag;
        pv    = 1;
    endtask

    task automatic run_all();
        // R9: reset holds outputs clear
        op_i = 3'd4; a_i = 8'hA5; b_i = 8'h5A;
        repeat (3) @(negedge clk_i);
        chk(res_o == 8'h00, "R9", int'(res_o), 0);
        chk(cout_o == 1'b0, "R9", int'(cout_o), 0);
        rst_ni = 1'b1;

        step(4, 8'hFF, 8'h01, "R1");
        step(4, 8'hFF, 8'hFF, "R1");
        step(4, 8'h0F, 8'h01, "R10");
        step(5, 8'h10, 8'h01, "R10");
        step(5, 8'h00, 8'h01, "R2");
        step(5, 8'h5C, 8'h5C, "R2");
        step(5, 8'hFF, 8'h00, "R2");
        step(1, 8'hF0, 8'h3C, "R3");
        step(2, 8'hF0, 8'h0F, "R4");
        step(3, 8'hFF, 8'hFF, "R5");
        step(0, 8'hFF, 8'h00, "R6");
        step(6, 8'h00, 8'hFF, "R6");
        step(7, 8'hAA, 8'h55, "R6");
        step(4, 8'h80, 8'h80, "R1");
        for (int i = 0; i < 3000; i++)
            step(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), "");
        step(0, 0, 0, "R6");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk_i);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule